// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block sits between an 8-bit CPU bus and the internal state of a tile video processor. The CPU picks one of eight register slots with a 3-bit select and issues single-cycle read or write strobes. Five slots are decoded here: control, status, scroll, video address and data. The other slots belong to neighbouring blocks and are ignored. The data slot reaches a 16K video memory through a 14-bit address, which steps by 1 or by 32 after every data access. The memory port is synchronous: a read issued in one cycle returns its byte in the next.

The status slot has side effects. Reading it returns the vertical-blank flag and then clears that flag. The read also rewinds the first/second write toggle, which the scroll slot and the address slot share. Data reads are delayed by one access: a read returns the byte that an earlier read left in a buffer, then refills the buffer from the current address. Addresses whose upper six bits are all ones form the palette window. Reads there bypass the buffer. A frame-timing pulse raises the vertical-blank flag. An interrupt line follows that flag, gated by a control bit.

Top module: `vpu_regport`

## Requirements
- R1: After reset the control register, scroll values, video address, write toggle, read buffer, vertical-blank flag, `cpu_rdata` and `nmi_o` are all zero.
- R2: Control bit 2 sets the address step applied after each data-slot read or write: 0 steps by 1, 1 steps by 32. The address wraps within 14 bits.
- R3: `nmi_o` is 1 exactly while the vertical-blank flag and control bit 7 are both 1.
- R4: A cycle with `vbl_start_i` high sets the vertical-blank flag. A status read (select 2) returns the flag in bit 7, `vram_lock_i` in bit 4 and zero in all other bits, then clears the flag. If the pulse and the read fall in the same cycle, the flag stays set.
- R5: A status read resets the write toggle, so the next scroll or address write is treated as the first write.
- R6: The address slot (select 6) takes the high byte on its first write and the low byte on its second. Only bits 5:0 of the high byte are kept.
- R7: The scroll slot (select 5) takes the horizontal value on its first write and the vertical value on its second. Scroll writes and address writes advance the same toggle.
- R8: A data-slot read (select 7) outside the palette window returns the buffer contents in the cycle after the strobe. Every data read then reloads the buffer with the memory byte at the address used. Back-to-back reads in consecutive cycles return consistent data.
- R9: A data-slot read whose address has bits 13:8 equal to 3F hex returns the memory byte at that address directly, in the cycle after the strobe.
- R10: A data-slot write drives `mem_we_o` with `cpu_wdata` at the current address while `vram_lock_i` is 0. While the lock is 1 no memory write occurs, but the address still steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 3 | Register slot select |
| cpu_wr | input | 1 | Single-cycle write strobe |
| cpu_rd | input | 1 | Single-cycle read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle after `cpu_rd`, zero otherwise |
| vbl_start_i | input | 1 | Frame-timing pulse marking the start of vertical blank |
| vram_lock_i | input | 1 | Blocks video-memory writes, reported in status bit 4 |
| nmi_o | output | 1 | Interrupt request to the CPU |
| ctrl_o | output | 8 | Current control register |
| scroll_x_o | output | 8 | Horizontal scroll value |
| scroll_y_o | output | 8 | Vertical scroll value |
| mem_addr_o | output | 14 | Video-memory address |
| mem_we_o | output | 1 | Video-memory write enable |
| mem_re_o | output | 1 | Video-memory read enable |
| mem_wdata_o | output | 8 | Video-memory write data |
| mem_rdata_i | input | 8 | Video-memory read data, one cycle after `mem_re_o` |

## Verification
The hardest case to reach is a data read issued in the cycle right after another data read. In that cycle the buffer is being refilled at the same edge where the second read captures the byte it will return. The bench holds the read strobe high for two consecutive cycles. It expects the second byte to equal the memory content at the first address, not the stale buffer. The same-cycle collision of a vertical-blank pulse with a status read is set up by driving both in one cycle. A second status read then shows that the flag survived.

// File: rtl/vpu_regport_pkg.sv
package vpu_regport_pkg;

   typedef enum logic [2:0] {
      SLOT_CTRL = 3'd0,
      SLOT_STAT = 3'd2,
      SLOT_SCRL = 3'd5,
      SLOT_ADDR = 3'd6,
      SLOT_DATA = 3'd7
   } slot_e;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_HOLD = 2'd1,
      RK_MEM  = 2'd2
   } rd_kind_e;

   localparam int CTRL_STEP_BIT = 2;
   localparam int CTRL_NMI_BIT  = 7;
   localparam int STAT_VBL_BIT  = 7;
   localparam int STAT_LOCK_BIT = 4;

endpackage

// File: rtl/vpu_status.sv
module vpu_status
   import vpu_regport_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vbl_set,
   input  logic          stat_rd,
   input  logic          nmi_en,
   input  logic          lock,
   output logic [DW-1:0] stat_byte,
   output logic          nmi
);

   logic vbl_q;

   generate
      if (DW <= STAT_VBL_BIT) begin : g_bad_dw
         $error("vpu_status: DW too narrow for the status layout");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vbl_q <= 1'b0;
      end else if (vbl_set) begin
         vbl_q <= 1'b1;
      end else if (stat_rd) begin
         vbl_q <= 1'b0;
      end
   end

   always_comb begin
      stat_byte                = '0;
      stat_byte[STAT_VBL_BIT]  = vbl_q;
      stat_byte[STAT_LOCK_BIT] = lock;
   end

   assign nmi = vbl_q & nmi_en;

   AST_VBL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      vbl_set |=> vbl_q); // R4
   AST_VBL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !vbl_set) |=> !vbl_q); // R4

endmodule

// File: rtl/vpu_addr_scroll.sv
module vpu_addr_scroll #(
   parameter int AW       = 14,
   parameter int DW       = 8,
   parameter int ROW_STEP = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_scrl,
   input  logic          wr_addr,
   input  logic          data_acc,
   input  logic          step_wide,
   input  logic          tog_clr,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] scroll_x,
   output logic [DW-1:0] scroll_y,
   output logic          toggle
);

   localparam logic [AW-1:0] STEP_ONE  = AW'(1);
   localparam logic [AW-1:0] STEP_WIDE = AW'(ROW_STEP);

   logic [AW-1:0] step_amt;

   generate
      if (ROW_STEP <= 0 || ROW_STEP >= (1 << AW)) begin : g_bad_step
         $error("vpu_addr_scroll: ROW_STEP outside address range");
      end
      if ((ROW_STEP & (ROW_STEP - 1)) != 0) begin : g_bad_pow2
         $error("vpu_addr_scroll: ROW_STEP must be a power of two");
      end
   endgenerate

   assign step_amt = step_wide ? STEP_WIDE : STEP_ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         toggle <= 1'b0;
      end else if (tog_clr) begin
         toggle <= 1'b0;
      end else if (wr_scrl || wr_addr) begin
         toggle <= ~toggle;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scroll_x <= '0;
         scroll_y <= '0;
      end else if (wr_scrl) begin
         if (!toggle) scroll_x <= wdata;
         else         scroll_y <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (wr_addr) begin
         if (!toggle) addr <= AW'({wdata, addr[7:0]});
         else         addr <= {addr[AW-1:8], wdata};
      end else if (data_acc) begin
         addr <= addr + step_amt;
      end
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc |=> addr == $past(addr + step_amt)); // R2
   AST_TOGGLE_RST: assert property (@(posedge clk) disable iff (!rst_n)
      tog_clr |=> !toggle); // R5
   AST_HIGH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr && !toggle && !tog_clr) |=> addr[AW-1:8] == $past(wdata[AW-9:0])); // R6

endmodule

// File: rtl/vpu_read_path.sv
module vpu_read_path
   import vpu_regport_pkg::*;
#(
   parameter int            AW         = 14,
   parameter int            DW         = 8,
   parameter bit            PAL_BYPASS = 1'b1,
   parameter logic [AW-9:0] PAL_TAG    = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stat,
   input  logic          rd_data,
   input  logic [DW-1:0] stat_byte,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] cpu_rdata
);

   rd_kind_e      kind_q;
   logic [DW-1:0] hold_q;
   logic [DW-1:0] buf_q;
   logic          pend_q;
   logic          pal_hit;
   logic [DW-1:0] buf_fwd;

   generate
      if (PAL_BYPASS) begin : g_pal
         assign pal_hit = (addr[AW-1:8] == PAL_TAG);
      end else begin : g_nopal
         assign pal_hit = 1'b0;
      end
   endgenerate

   assign buf_fwd = pend_q ? mem_rdata : buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= RK_NONE;
         hold_q <= '0;
         buf_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= rd_data;
         if (pend_q) buf_q <= mem_rdata;
         if (rd_stat) begin
            kind_q <= RK_HOLD;
            hold_q <= stat_byte;
         end else if (rd_data) begin
            kind_q <= pal_hit ? RK_MEM : RK_HOLD;
            hold_q <= buf_fwd;
         end else begin
            kind_q <= RK_NONE;
         end
      end
   end

   always_comb begin
      unique case (kind_q)
         RK_MEM:  cpu_rdata = mem_rdata;
         RK_HOLD: cpu_rdata = hold_q;
         default: cpu_rdata = '0;
      endcase
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stat && !rd_data) |=> cpu_rdata == '0); // R8

endmodule

// File: rtl/vpu_regport.sv
module vpu_regport
   import vpu_regport_pkg::*;
#(
   parameter int AW         = 14,
   parameter int DW         = 8,
   parameter int ROW_STEP   = 32,
   parameter bit PAL_BYPASS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    cpu_sel,
   input  logic          cpu_wr,
   input  logic          cpu_rd,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   input  logic          vbl_start_i,
   input  logic          vram_lock_i,
   output logic          nmi_o,
   output logic [DW-1:0] ctrl_o,
   output logic [DW-1:0] scroll_x_o,
   output logic [DW-1:0] scroll_y_o,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_we_o,
   output logic          mem_re_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i
);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("vpu_regport: data path must be 8 bits");
      end
      if (AW < 9 || AW > 16) begin : g_bad_aw
         $error("vpu_regport: AW must lie in 9..16");
      end
   endgenerate

   logic          wr_ctrl, wr_scrl, wr_addr, wr_data;
   logic          rd_stat, rd_data, data_acc;
   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] stat_byte;
   logic [AW-1:0] vaddr;
   logic          toggle;

   assign wr_ctrl  = cpu_wr && (cpu_sel == SLOT_CTRL);
   assign wr_scrl  = cpu_wr && (cpu_sel == SLOT_SCRL);
   assign wr_addr  = cpu_wr && (cpu_sel == SLOT_ADDR);
   assign wr_data  = cpu_wr && (cpu_sel == SLOT_DATA);
   assign rd_stat  = cpu_rd && (cpu_sel == SLOT_STAT);
   assign rd_data  = cpu_rd && (cpu_sel == SLOT_DATA);
   assign data_acc = wr_data || rd_data;

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= cpu_wdata;
   end

   vpu_status #(.DW(DW)) status_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .vbl_set   (vbl_start_i),
      .stat_rd   (rd_stat),
      .nmi_en    (ctrl_q[CTRL_NMI_BIT]),
      .lock      (vram_lock_i),
      .stat_byte (stat_byte),
      .nmi       (nmi_o)
   );

   vpu_addr_scroll #(.AW(AW), .DW(DW), .ROW_STEP(ROW_STEP)) addr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_scrl   (wr_scrl),
      .wr_addr   (wr_addr),
      .data_acc  (data_acc),
      .step_wide (ctrl_q[CTRL_STEP_BIT]),
      .tog_clr   (rd_stat),
      .wdata     (cpu_wdata),
      .addr      (vaddr),
      .scroll_x  (scroll_x_o),
      .scroll_y  (scroll_y_o),
      .toggle    (toggle)
   );

   vpu_read_path #(.AW(AW), .DW(DW), .PAL_BYPASS(PAL_BYPASS)) rdp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_stat   (rd_stat),
      .rd_data   (rd_data),
      .stat_byte (stat_byte),
      .addr      (vaddr),
      .mem_rdata (mem_rdata_i),
      .cpu_rdata (cpu_rdata)
   );

   assign ctrl_o      = ctrl_q;
   assign mem_addr_o  = vaddr;
   assign mem_we_o    = wr_data && !vram_lock_i;
   assign mem_re_o    = rd_data;
   assign mem_wdata_o = cpu_wdata;

   AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_o) |-> ($past(vbl_start_i) || $past(wr_ctrl))); // R3
   AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      vram_lock_i |-> !mem_we_o); // R10
   AST_TOGGLE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_scrl && !toggle) |=> toggle); // R7

endmodule

// File: tb/vpu_regport_tb_top.sv
`timescale 1ns/1ps
module vpu_regport_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cpu_sel = '0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [7:0] cpu_wdata = '0, cpu_rdata;
   logic       vbl_start_i = 1'b0, vram_lock_i = 1'b0, nmi_o;
   logic [7:0] ctrl_o, scroll_x_o, scroll_y_o;
   logic [13:0] mem_addr_o;
   logic       mem_we_o, mem_re_o;
   logic [7:0] mem_wdata_o;
   logic [7:0] mem_rdata_i = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   vpu_regport dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .vbl_start_i(vbl_start_i), .vram_lock_i(vram_lock_i), .nmi_o(nmi_o),
      .ctrl_o(ctrl_o), .scroll_x_o(scroll_x_o), .scroll_y_o(scroll_y_o),
      .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
   );

   function automatic logic [7:0] pat(input logic [13:0] a);
      return a[7:0] ^ {a[13:8], 2'b11};
   endfunction

   always @(posedge clk) if (mem_re_o) mem_rdata_i <= pat(mem_addr_o);

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk); cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk); cpu_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] s, output logic [7:0] d);
      @(negedge clk); cpu_sel = s; cpu_rd = 1'b1;
      @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
   endtask

   task automatic vbl_pulse();
      @(negedge clk); vbl_start_i = 1'b1;
      @(negedge clk); vbl_start_i = 1'b0;
   endtask

   task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
      logic [7:0] d;
      bus_rd(3'd2, d);
      bus_wr(3'd6, hi);
      bus_wr(3'd6, lo);
   endtask

   task automatic t_reset();
      chk("R1 rdata", cpu_rdata, 0);
      chk("R1 nmi", nmi_o, 0);
      chk("R1 addr", mem_addr_o, 0);
      chk("R1 ctrl", ctrl_o, 0);
      chk("R1 scroll", {scroll_x_o, scroll_y_o}, 0);
   endtask

   task automatic t_addr_mask();
      set_addr(8'hFF, 8'h10);
      chk("R6 high masked", mem_addr_o, 14'h3F10);
      set_addr(8'h12, 8'h34);
      chk("R6 high then low", mem_addr_o, 14'h1234);
   endtask

   task automatic t_step();
      logic [7:0] d;
      bus_wr(3'd0, 8'h00);
      bus_rd(3'd7, d);
      chk("R2 step by 1", mem_addr_o, 14'h1235);
      bus_wr(3'd0, 8'h04);
      bus_wr(3'd7, 8'h00);
      chk("R2 step by 32", mem_addr_o, 14'h1255);
      set_addr(8'h3F, 8'hF0);
      bus_wr(3'd7, 8'h00);
      chk("R2 wrap 14 bits", mem_addr_o, 14'h0010);
      bus_wr(3'd0, 8'h00);
   endtask

   task automatic t_scroll();
      logic [7:0] d;
      bus_rd(3'd2, d);
      bus_wr(3'd5, 8'h11);
      bus_wr(3'd5, 8'h22);
      chk("R7 horizontal", scroll_x_o, 8'h11);
      chk("R7 vertical", scroll_y_o, 8'h22);
      set_addr(8'h01, 8'h02);
      bus_rd(3'd2, d);
      bus_wr(3'd5, 8'h33);
      bus_wr(3'd6, 8'h05);
      chk("R7 shared toggle low byte", mem_addr_o, 14'h0105);
      chk("R7 scroll x kept", scroll_x_o, 8'h33);
      bus_rd(3'd2, d);
      bus_wr(3'd6, 8'h07);
      chk("R5 toggle reset by status", mem_addr_o[13:8], 6'h07);
   endtask

   task automatic t_palette();
      logic [7:0] d;
      set_addr(8'h3F, 8'h05);
      bus_rd(3'd7, d);
      chk("R9 palette direct", d, pat(14'h3F05));
   endtask

   task automatic t_buffered();
      logic [7:0] d1, d2;
      set_addr(8'h02, 8'h10);
      bus_rd(3'd7, d1);
      chk("R8 stale buffer", d1, pat(14'h3F05));
      bus_rd(3'd7, d1);
      chk("R8 buffered byte", d1, pat(14'h0210));
      @(negedge clk); cpu_sel = 3'd7; cpu_rd = 1'b1;
      @(negedge clk); d1 = cpu_rdata;
      @(negedge clk); cpu_rd = 1'b0; d2 = cpu_rdata;
      chk("R8 back-to-back first", d1, pat(14'h0211));
      chk("R8 back-to-back second", d2, pat(14'h0212));
      @(negedge clk);
      chk("R8 idle rdata zero", cpu_rdata, 0);
   endtask

   task automatic t_nmi();
      logic [7:0] d;
      bus_rd(3'd2, d);
      bus_wr(3'd0, 8'h80);
      chk("R3 nmi low without flag", nmi_o, 0);
      vbl_pulse();
      chk("R3 nmi high", nmi_o, 1);
      bus_wr(3'd0, 8'h00);
      chk("R3 nmi masked", nmi_o, 0);
      bus_wr(3'd0, 8'h80);
      chk("R3 nmi reenabled", nmi_o, 1);
      bus_rd(3'd2, d);
      chk("R4 flag in bit 7", d, 8'h80);
      chk("R3 nmi drops after status read", nmi_o, 0);
      bus_wr(3'd0, 8'h00);
   endtask

   task automatic t_status();
      logic [7:0] d;
      vram_lock_i = 1'b1;
      vbl_pulse();
      bus_rd(3'd2, d);
      chk("R4 status flag and lock", d, 8'h90);
      bus_rd(3'd2, d);
      chk("R4 flag cleared by read", d, 8'h10);
      @(negedge clk); vbl_start_i = 1'b1; cpu_sel = 3'd2; cpu_rd = 1'b1;
      @(negedge clk); vbl_start_i = 1'b0; cpu_rd = 1'b0; d = cpu_rdata;
      chk("R4 collision returns old flag", d, 8'h10);
      bus_rd(3'd2, d);
      chk("R4 collision keeps flag set", d, 8'h90);
      vram_lock_i = 1'b0;
   endtask

   task automatic t_write_lock();
      set_addr(8'h00, 8'h40);
      @(negedge clk); cpu_sel = 3'd7; cpu_wdata = 8'hA5; cpu_wr = 1'b1;
      #1;
      chk("R10 write enable", mem_we_o, 1);
      chk("R10 write address", mem_addr_o, 14'h0040);
      chk("R10 write data", mem_wdata_o, 8'hA5);
      @(negedge clk); cpu_wr = 1'b0;
      chk("R10 step after write", mem_addr_o, 14'h0041);
      vram_lock_i = 1'b1;
      @(negedge clk); cpu_wdata = 8'h5A; cpu_wr = 1'b1;
      #1;
      chk("R10 locked write suppressed", mem_we_o, 0);
      @(negedge clk); cpu_wr = 1'b0;
      chk("R10 locked write still steps", mem_addr_o, 14'h0042);
      vram_lock_i = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_mask();
      t_step();
      t_scroll();
      t_palette();
      t_buffered();
      t_nmi();
      t_status();
      t_write_lock();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog all-requirements actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule